// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O controller

This block drives and samples up to 32 general-purpose pins and turns activity on them into interrupts. Software reaches it over a small word-wide register interface. A write strobe takes effect at the clock edge where it is seen. A read strobe returns its word one cycle later, flagged by a valid pulse.

Every piece of per-line state has two write addresses, one that sets bits and one that clears them. This state covers the output value, the pin direction, interrupt enable, interrupt mask, trigger type, polarity, input filtering and a dual-edge override. Software can therefore change one line without a read-modify-write.

Each input passes through a two-flop synchronizer. Each line can raise a rising-edge, falling-edge, dual-edge, active-high or active-low interrupt. Edge events are held until software acknowledges them. All pending lines are ORed into one interrupt output, and that output is gated by a single combine-enable bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A read strobe in one cycle gives `bus_rvalid` high with the addressed word on `bus_rdata` in the next cycle, and `bus_rvalid` is low after any cycle without a read strobe. Offsets that are not listed here read as zero, including the acknowledge offset 0x078.
- R2: Eight per-line registers each have a set offset and a clear offset. The set offset is at the base address and the clear offset is at base+4. Writing ones to the set offset sets those bits, writing ones to the clear offset clears them, and bits written as zero stay unchanged. The bases are: output value 0x000, direction 0x010, enable 0x020, mask 0x030, trigger type 0x040, polarity 0x050, filter 0x060 and dual-edge 0x0B0. Reading either offset of a pair returns the register.
- R3: `pin_out` follows the output-value register and `pin_oe` follows the direction register, where 1 means output. The direction register can also be read at 0x018.
- R4: Offset 0x080 returns the pin inputs after two synchronizing flops.
- R5: When trigger type is 1, polarity 1 makes a line detect rising edges and polarity 0 makes it detect falling edges.
- R6: When trigger type is 0 and dual-edge is 0, the line is level-sensitive. It is pending while the input is high if polarity is 1, and while the input is low if polarity is 0. The level condition is not held after the input returns.
- R7: When a line's dual-edge bit is 1, the line latches on both edges whatever its type and polarity bits are. The dual-edge register can also be read at 0x0B8.
- R8: An edge latches only while the line's enable bit is 1. A latched edge stays until a one is written to that line's bit at 0x078.
- R9: Offset 0x070 shows, bit n for line n, the pending condition ANDed with enable and with NOT mask.
- R10: Bit 0 of offset 0x0A0 is the combine-enable. `irq_out` is high exactly when this bit is 1 and any status bit is 1.
- R11: With a line's filter bit set, an input pulse lasting one cycle causes no edge, while a change held for several cycles is still seen. With the filter bit clear, the same pulse latches an edge.
- R12: Reset clears every register, every latched event and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_in | input | NLINES (32) | Pin inputs |
| pin_out | output | NLINES (32) | Pin output values |
| pin_oe | output | NLINES (32) | Pin output enables, 1 = drive |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults, NLINES = 32 and AW = 8. With these values every register is a full word, so random set and clear patterns reach bit 31 and the highest offset, 0x0B8.

Random writes mix all five trigger modes across the lines at the same time. Pin changes, single-cycle glitches and acknowledges are scattered between those writes. This exercises latch-versus-level selection, enable gating and filter suppression on many lines in the same cycle.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NLINES = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_out
);
  localparam int NCFG = 8;
  localparam logic [AW-1:0] A_DIR_ST  = AW'(8'h18);
  localparam logic [AW-1:0] A_STATUS  = AW'(8'h70);
  localparam logic [AW-1:0] A_ACK     = AW'(8'h78);
  localparam logic [AW-1:0] A_EXT     = AW'(8'h80);
  localparam logic [AW-1:0] A_COMB    = AW'(8'hA0);
  localparam logic [AW-1:0] A_DUAL_ST = AW'(8'hB8);
  localparam logic [AW-1:0] A_DAT_CLR = AW'(8'h04);
  localparam logic [AW-1:0] A_DIR_SET = AW'(8'h10);
  localparam logic [AW-1:0] A_MSK_SET = AW'(8'h30);

  function automatic logic [AW-1:0] cfg_base(input int k);
    case (k)
      0: return AW'(8'h00);
      1: return AW'(8'h10);
      2: return AW'(8'h20);
      3: return AW'(8'h30);
      4: return AW'(8'h40);
      5: return AW'(8'h50);
      6: return AW'(8'h60);
      default: return AW'(8'hB0);
    endcase
  endfunction

  logic [NLINES-1:0] cfg [NCFG];
  logic              comb_q;
  logic [NLINES-1:0] wbits;
  logic [NLINES-1:0] s1, s2, s3, dfilt, vprev, latch_q;
  logic [NLINES-1:0] v, rise, fall, ev, edge_mode, level, int_status, ack_bits;
  logic [31:0]       rd_word;

  assign wbits    = bus_wdata[NLINES-1:0];
  assign pin_out  = cfg[0];
  assign pin_oe   = cfg[1];
  assign ack_bits = (bus_wr && bus_addr == A_ACK) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) cfg[k] <= '0;
      comb_q <= 1'b0;
    end else if (bus_wr) begin
      for (int k = 0; k < NCFG; k++) begin
        if (bus_addr == cfg_base(k))
          cfg[k] <= cfg[k] | wbits;
        else if (bus_addr == cfg_base(k) + AW'(4))
          cfg[k] <= cfg[k] & ~wbits;
      end
      if (bus_addr == A_COMB) comb_q <= bus_wdata[0];
    end
  end

  assign v         = (cfg[6] & dfilt) | (~cfg[6] & s2);
  assign rise      = v & ~vprev;
  assign fall      = ~v & vprev;
  assign edge_mode = cfg[4] | cfg[7];
  assign ev        = (cfg[7] & (rise | fall)) |
                     (~cfg[7] & ((cfg[5] & rise) | (~cfg[5] & fall)));
  assign level     = ~edge_mode & ((cfg[5] & v) | (~cfg[5] & ~v));
  assign int_status = ((edge_mode & latch_q) | level) & cfg[2] & ~cfg[3];
  assign irq_out   = comb_q & (|int_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      dfilt <= '0; vprev <= '0; latch_q <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < NLINES; i++)
        if (s2[i] == s3[i]) dfilt[i] <= s2[i];
      vprev   <= v;
      latch_q <= (latch_q & ~ack_bits) | (ev & cfg[2] & edge_mode);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NCFG; k++)
      if (bus_addr == cfg_base(k) || bus_addr == cfg_base(k) + AW'(4))
        rd_word[NLINES-1:0] = cfg[k];
    case (bus_addr)
      A_DIR_ST:  rd_word[NLINES-1:0] = cfg[1];
      A_DUAL_ST: rd_word[NLINES-1:0] = cfg[7];
      A_STATUS:  rd_word[NLINES-1:0] = int_status;
      A_EXT:     rd_word[NLINES-1:0] = s2;
      A_COMB:    rd_word[0] = comb_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  a_r2_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DAT_CLR) |=> ((pin_out & $past(wbits)) == '0));
  a_r3_dir_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR_SET) |=> ((pin_oe & $past(wbits)) == $past(wbits)));
  a_r9_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSK_SET) |=> ((int_status & $past(wbits)) == '0));
  a_r10_comb_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_COMB && !bus_wdata[0]) |=> !irq_out);
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m [8];
  logic        mcomb;
  logic [31:0] mlatch, mpins;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NLINES(32), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out));

  function automatic logic [7:0] base_of(input int k);
    case (k)
      0: return 8'h00; 1: return 8'h10; 2: return 8'h20; 3: return 8'h30;
      4: return 8'h40; 5: return 8'h50; 6: return 8'h60; default: return 8'hB0;
    endcase
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] em = m[4] | m[7];
    logic [31:0] lvl = (m[5] & mpins) | (~m[5] & ~mpins);
    return ((em & mlatch) | (~em & lvl)) & m[2] & ~m[3];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    for (int k = 0; k < 8; k++)
      if (a == base_of(k) || a == base_of(k) + 8'd4) return m[k];
    case (a)
      8'h18: return m[1];
      8'hB8: return m[7];
      8'h70: return exp_status();
      8'h80: return mpins;
      8'hA0: return {31'b0, mcomb};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (a == base_of(k)) m[k] = m[k] | d;
      else if (a == base_of(k) + 8'd4) m[k] = m[k] & ~d;
    end
    if (a == 8'h78) mlatch = mlatch & ~d;
    if (a == 8'hA0) mcomb = d[0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    #2;
    d = bus_rdata; v = bus_rvalid;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(tag, d, exp_read(a));
  endtask

  task automatic set_pins(input logic [31:0] nv);
    logic [31:0] rise = nv & ~mpins, fall = ~nv & mpins;
    logic [31:0] ev = (m[7] & (rise | fall)) | (~m[7] & ((m[5] & rise) | (~m[5] & fall)));
    @(negedge clk);
    pin_in = nv;
    repeat (8) @(posedge clk);
    mlatch = mlatch | (ev & m[2] & (m[4] | m[7]));
    mpins = nv;
  endtask

  task automatic glitch(input logic [31:0] bits);
    @(negedge clk);
    pin_in = mpins ^ bits;
    @(negedge clk);
    pin_in = mpins;
    repeat (8) @(posedge clk);
    mlatch = mlatch | (bits & m[2] & (m[4] | m[7]) & ~m[6]);
  endtask

  task automatic chk_irq(input string tag);
    n_chk++;
    if (irq_out !== (mcomb & (|exp_status()))) begin
      n_bad++;
      $display("FAIL %s: irq_out got %b expected %b", tag, irq_out, mcomb & (|exp_status()));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) m[k] = '0;
    mcomb = 1'b0; mlatch = '0; mpins = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    #1;
    chk("R12 pin_oe", pin_oe, 0);
    chk("R12 pin_out", pin_out, 0);
    chk("R12 irq_out", {31'b0, irq_out}, 0);
    chk("R12 rvalid", {31'b0, bus_rvalid}, 0);
    for (int k = 0; k < 8; k++) chk_rd("R12 cfg", base_of(k));

    rd(8'h0C, d, v);
    chk("R1 unmapped", d, 0);
    chk("R1 rvalid", {31'b0, v}, 1);
    @(posedge clk); #2;
    chk("R1 rvalid low", {31'b0, bus_rvalid}, 0);

    wr(8'h00, 32'hF0F0_1234);
    wr(8'h04, 32'h0000_1030);
    wr(8'h10, 32'h8000_00FF);
    wr(8'h14, 32'h0000_000F);
    chk("R2 data", pin_out, m[0]);
    chk("R3 oe", pin_oe, 32'h8000_00F0);
    chk_rd("R2 data read", 8'h04);
    chk_rd("R3 dir status", 8'h18);

    set_pins(32'hA5A5_0001);
    chk_rd("R4 ext", 8'h80);

    wr(8'h20, 32'h0000_000F);
    wr(8'hA0, 32'h1);
    wr(8'h40, 32'h0000_0003);
    wr(8'h50, 32'h0000_0005);
    chk_rd("R6 level status", 8'h70);
    set_pins(32'hA5A5_000E);
    chk_rd("R5 edge status", 8'h70);
    chk_irq("R10 irq");
    wr(8'h78, 32'h0000_0003);
    chk_rd("R8 ack status", 8'h70);
    wr(8'hB0, 32'h0000_0001);
    chk_rd("R7 dual status read", 8'hB8);
    set_pins(32'hA5A5_000F);
    chk_rd("R7 dual rise", 8'h70);
    wr(8'h78, 32'h1);
    set_pins(32'hA5A5_000E);
    chk_rd("R7 dual fall", 8'h70);
    wr(8'h30, 32'h0000_000F);
    chk_rd("R9 masked", 8'h70);
    chk_irq("R10 masked irq");
    wr(8'h34, 32'h0000_000F);
    wr(8'h24, 32'h1);
    set_pins(32'hA5A5_000F);
    chk_rd("R8 disabled no latch", 8'h70);
    wr(8'h20, 32'h1);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h60, 32'h1);
    glitch(32'h1);
    chk_rd("R11 filtered glitch", 8'h70);
    set_pins(32'hA5A5_000E);
    chk_rd("R11 held change", 8'h70);
    wr(8'h64, 32'h1);
    wr(8'h78, 32'h1);
    glitch(32'h1);
    chk_rd("R11 unfiltered glitch", 8'h70);
    wr(8'hA0, 32'h0);
    chk_irq("R10 comb off");

    for (int it = 0; it < 500; it++) begin
      int op = $urandom % 10;
      if (op < 5) begin
        int k = $urandom % 8;
        wr(base_of(k) + (($urandom % 2) ? 8'd4 : 8'd0), $urandom & $urandom);
      end else if (op == 5) wr(8'h78, $urandom);
      else if (op == 6) wr(8'hA0, $urandom);
      else if (op == 7) glitch($urandom & $urandom & $urandom);
      else set_pins(mpins ^ ($urandom & $urandom));
      chk_rd("R9 status", 8'h70);
      chk_irq("R10 irq");
      begin
        logic [7:0] al [18] = '{8'h00,8'h04,8'h10,8'h14,8'h20,8'h24,8'h30,8'h34,
          8'h40,8'h44,8'h50,8'h54,8'h60,8'hB4,8'h18,8'hB8,8'h80,8'h78};
        chk_rd("R2 readback", al[$urandom % 18]);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule